// File: doc/BRIEF.md
# MIB Statistics Counter Bank

A bank of six event-statistics counters for a wireless MAC. Four frame-event counters track RTS successes, RTS failures, ACK failures and FCS failures. Each is fed by a single-cycle pulse. Two PHY-error counters count error reports whose type is enabled in a per-counter mask register. Every counter saturates at a fixed threshold. The threshold is not a power of two. Reaching it sets a sticky warning flag and drives a level interrupt. Reading a counter returns its value and zeroes it, so software always sees the count since the last read.

A shared control word acts on the whole bank:
- A freeze bit holds every counter still and also suspends read-clear.
- A self-clearing clear bit zeroes the whole bank in one cycle.
- A self-clearing test strobe adds one to every counter.

Software reaches the bank through a register port with a valid/ready request channel and a valid/ready read-response channel. The response channel holds a single entry. A read response stays valid and unchanged until the consumer accepts it. While an unaccepted response is pending, `req_ready` is low and no new request is taken. Writes produce no response. A read takes effect, including its clear, in the cycle its request is accepted. The response appears one cycle later.

Top module: `mib_stat_bank`

## Requirements
- R1: After reset every counter, both mask registers and the control word read zero and `irq` is low. Address map: 0 control, 1 RTS-success counter, 2 RTS-failure counter, 3 ACK-failure counter, 4 FCS-failure counter, 5 PHY counter 0, 6 mask 0, 7 PHY counter 1, 8 mask 1. The control word reads bit 0 = warning flag, bit 1 = freeze, bits 2 and 3 as zero. Writes to counter addresses change nothing.
- R2: `evt_pulse` bit 0 counts RTS successes, bit 1 RTS failures, bit 2 ACK failures and bit 3 FCS failures. Each cycle a bit is high adds one to its counter. A counter gains at most one per cycle, even when a strobe coincides.
- R3: Frame-event counters stop at `FRAME_THR` (default 0xC000) and PHY counters stop at `PHY_THR` (default 0xC00000). Further increments leave them at the threshold, and they never wrap.
- R4: A read response carries the counter value before the read, and the counter is zero afterwards. If the counter's own increment arrives in the accepting cycle, it holds 1 afterwards.
- R5: When `phy_err_valid` is high with type t, PHY counter k increments exactly when bit t of mask k is set. Masks are read/write.
- R6: While freeze (control bit 1) is set, event pulses, PHY errors and the strobe change no counter, and reads return the value without clearing it.
- R7: Writing 1 to control bit 2 zeroes all counters in the next cycle, even while frozen. It takes priority over a strobe or event in the same cycle, and it reads back 0.
- R8: Writing 1 to control bit 3 with bit 1 clear, while not frozen, adds one to all six counters. The bit reads back 0.
- R9: The warning flag (control bit 0) is set once any counter is at its threshold. It stays set after the counter is read. Only a control write with bit 0 = 0 clears it, and only while no counter is at threshold.
- R10: `irq` is high whenever any counter is at its threshold or the warning flag is set, and low otherwise.
- R11: A read response is held with stable data while `rsp_valid` is high and `rsp_ready` is low. During that time `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 4 | Frame-event pulses: RTS ok, RTS fail, ACK fail, FCS fail |
| phy_err_valid | input | 1 | A PHY error of type `phy_err_type` occurred this cycle |
| phy_err_type | input | TYPE_W (5) | PHY error type index |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Register address |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | DATA_W (32) | Read response data |
| irq | output | 1 | Level interrupt: counter at threshold or warning set |

## Verification
The bound checker watches properties that hold on every cycle:
- no counter ever exceeds its threshold;
- `irq` is high whenever a counter is at threshold;
- a frozen bank keeps its counters unchanged unless cleared;
- a clear write empties the bank one cycle later;
- an accepted read of the RTS-success counter leaves it zero;
- the warning flag persists until cleared;
- a stalled response is held with stable data and with `req_ready` low.

Only the bench's scenarios can show the rest: the exact counts under mixed pulse patterns, mask selection by error type, strobe and clear priority, read-clear racing an event, and the path from saturation through warning to its release.

// File: rtl/mib_stat_pkg.sv
package mib_stat_pkg;
  localparam int NUM_FRAME = 4;
  localparam int NUM_PHY   = 2;
  localparam int NUM_CNT   = NUM_FRAME + NUM_PHY;

  localparam int ADR_CTRL = 0;

  // control word bit positions
  localparam int CTL_WARN = 0;
  localparam int CTL_FRZ  = 1;
  localparam int CTL_CLR  = 2;
  localparam int CTL_STB  = 3;

  // counter i: frame counters at 1..4, PHY counters at 5 and 7
  function automatic int cnt_addr(int i);
    return (i < NUM_FRAME) ? i + 1 : NUM_FRAME + 1 + 2 * (i - NUM_FRAME);
  endfunction

  // mask register of PHY counter j sits right after that counter
  function automatic int mask_addr(int j);
    return NUM_FRAME + 2 + 2 * j;
  endfunction
endpackage

// File: rtl/mib_sat_counter.sv
module mib_sat_counter #(
  parameter int           W   = 16,
  parameter logic [W-1:0] THR = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic         rd_clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_thr
);
  assign at_thr = (cnt >= THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr_all)        cnt <= '0;
    else if (rd_clr)         cnt <= inc ? W'(1) : '0;
    else if (inc && !at_thr) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mib_ctrl.sv
module mib_ctrl
  import mib_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wdata,
  input  logic       any_at_thr,
  output logic       freeze,
  output logic       warn,
  output logic       clr_all,
  output logic       strobe
);
  assign clr_all = wr_en & wdata[CTL_CLR];
  // the strobe needs the bank unfrozen before and after the write
  assign strobe  = wr_en & wdata[CTL_STB] & ~wdata[CTL_FRZ] & ~freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze <= 1'b0;
      warn   <= 1'b0;
    end else begin
      if (wr_en) freeze <= wdata[CTL_FRZ];
      if (any_at_thr)                    warn <= 1'b1;
      else if (wr_en && !wdata[CTL_WARN]) warn <= 1'b0;
    end
  end
endmodule

// File: rtl/mib_phy_mask.sv
module mib_phy_mask #(
  parameter int TYPES  = 32,
  parameter int TYPE_W = $clog2(TYPES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TYPES-1:0]  wdata,
  input  logic              err_valid,
  input  logic [TYPE_W-1:0] err_type,
  output logic [TYPES-1:0]  mask,
  output logic              hit
);
  assign hit = err_valid & mask[err_type];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask <= '0;
    else if (wr_en) mask <= wdata;
  end
endmodule

// File: rtl/mib_rd_port.sv
module mib_rd_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              rsp_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              req_ready,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign req_ready = ~rsp_valid | rsp_ready;
  assign rd_fire   = req_valid & req_ready & ~req_write;
  assign wr_fire   = req_valid & req_ready & req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mib_stat_bank.sv
module mib_stat_bank
  import mib_stat_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 4,
  parameter int                 FRAME_W   = 16,
  parameter logic [FRAME_W-1:0] FRAME_THR = 16'hC000,
  parameter int                 PHY_W     = 24,
  parameter logic [PHY_W-1:0]   PHY_THR   = 24'hC00000,
  parameter int                 PHY_TYPES = 32,
  parameter int                 TYPE_W    = $clog2(PHY_TYPES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FRAME-1:0] evt_pulse,
  input  logic                 phy_err_valid,
  input  logic [TYPE_W-1:0]    phy_err_type,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 irq
);
  logic rd_fire, wr_fire, wr_ctrl;
  logic freeze, warn, clr_all, strobe, any_at_thr;
  logic [NUM_CNT-1:0] at_thr, inc, rd_clr;
  logic [NUM_CNT*DATA_W-1:0] cnt_flat;
  logic [NUM_PHY*DATA_W-1:0] mask_flat;
  logic [NUM_PHY-1:0] phy_hit;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl    = wr_fire & (req_addr == ADDR_W'(ADR_CTRL));
  assign any_at_thr = |at_thr;
  assign irq        = warn | any_at_thr;

  mib_rd_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .rsp_ready(rsp_ready), .rd_data(rd_mux), .req_ready(req_ready),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  mib_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(req_wdata[3:0]),
    .any_at_thr(any_at_thr), .freeze(freeze), .warn(warn),
    .clr_all(clr_all), .strobe(strobe)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_rdclr
    assign rd_clr[i] = rd_fire & ~freeze & (req_addr == ADDR_W'(cnt_addr(i)));
  end

  for (genvar i = 0; i < NUM_FRAME; i++) begin : g_frame
    logic [FRAME_W-1:0] cnt;
    assign inc[i] = (evt_pulse[i] | strobe) & ~freeze;
    mib_sat_counter #(.W(FRAME_W), .THR(FRAME_THR)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .rd_clr(rd_clr[i]),
      .inc(inc[i]), .cnt(cnt), .at_thr(at_thr[i])
    );
    assign cnt_flat[i*DATA_W +: DATA_W] = DATA_W'(cnt);
  end

  for (genvar j = 0; j < NUM_PHY; j++) begin : g_phy
    localparam int K = NUM_FRAME + j;
    logic [PHY_W-1:0]     cnt;
    logic [PHY_TYPES-1:0] mask;
    mib_phy_mask #(.TYPES(PHY_TYPES), .TYPE_W(TYPE_W)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_fire & (req_addr == ADDR_W'(mask_addr(j)))),
      .wdata(req_wdata[PHY_TYPES-1:0]), .err_valid(phy_err_valid),
      .err_type(phy_err_type), .mask(mask), .hit(phy_hit[j])
    );
    assign inc[K] = (phy_hit[j] | strobe) & ~freeze;
    mib_sat_counter #(.W(PHY_W), .THR(PHY_THR)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .rd_clr(rd_clr[K]),
      .inc(inc[K]), .cnt(cnt), .at_thr(at_thr[K])
    );
    assign cnt_flat[K*DATA_W +: DATA_W]  = DATA_W'(cnt);
    assign mask_flat[j*DATA_W +: DATA_W] = DATA_W'(mask);
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == ADDR_W'(ADR_CTRL)) begin
      rd_mux[CTL_WARN] = warn;
      rd_mux[CTL_FRZ]  = freeze;
    end
    for (int i = 0; i < NUM_CNT; i++)
      if (req_addr == ADDR_W'(cnt_addr(i))) rd_mux = cnt_flat[i*DATA_W +: DATA_W];
    for (int j = 0; j < NUM_PHY; j++)
      if (req_addr == ADDR_W'(mask_addr(j))) rd_mux = mask_flat[j*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/mib_stat_bank_chk.sv
module mib_stat_bank_chk #(
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 4,
  parameter int                 NUM_CNT   = 6,
  parameter int                 NUM_FRAME = 4,
  parameter int                 FRAME_W   = 16,
  parameter logic [FRAME_W-1:0] FRAME_THR = 16'hC000,
  parameter int                 PHY_W     = 24,
  parameter logic [PHY_W-1:0]   PHY_THR   = 24'hC00000
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_write,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      wbit_warn,
  input logic                      wbit_clr,
  input logic                      evt0,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [DATA_W-1:0]         rsp_rdata,
  input logic                      irq,
  input logic                      freeze,
  input logic                      warn,
  input logic [NUM_CNT*DATA_W-1:0] cnt_flat
);
  logic fire, ctrl_wr, clr_wr, rd_rts_ok, hit_thr;
  assign fire      = req_valid & req_ready;
  assign ctrl_wr   = fire & req_write & (req_addr == '0);
  assign clr_wr    = ctrl_wr & wbit_clr;
  assign rd_rts_ok = fire & ~req_write & (req_addr == ADDR_W'(1));

  always_comb begin
    hit_thr = 1'b0;
    for (int i = 0; i < NUM_CNT; i++)
      if (i < NUM_FRAME) hit_thr |= (cnt_flat[i*DATA_W +: FRAME_W] == FRAME_THR);
      else               hit_thr |= (cnt_flat[i*DATA_W +: PHY_W] == PHY_THR);
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sat
    if (i < NUM_FRAME) begin : g_f
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_flat[i*DATA_W +: DATA_W] <= DATA_W'(FRAME_THR));
    end else begin : g_p
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_flat[i*DATA_W +: DATA_W] <= DATA_W'(PHY_THR));
    end
  end

  p_irq_at_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_thr |-> irq);

  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clr_wr) |=> $stable(cnt_flat));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt_flat == '0));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rts_ok && !freeze && !evt0) |=> (cnt_flat[DATA_W-1:0] == '0));

  p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warn && !(ctrl_wr && !wbit_warn)) |=> warn);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind mib_stat_bank mib_stat_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CNT(mib_stat_pkg::NUM_CNT),
  .NUM_FRAME(mib_stat_pkg::NUM_FRAME), .FRAME_W(FRAME_W),
  .FRAME_THR(FRAME_THR), .PHY_W(PHY_W), .PHY_THR(PHY_THR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .wbit_warn(req_wdata[0]),
  .wbit_clr(req_wdata[2]), .evt0(evt_pulse[0]), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq),
  .freeze(freeze), .warn(warn), .cnt_flat(cnt_flat)
);

// File: tb/mib_stat_bank_bench.sv
`timescale 1ns/1ps
module mib_stat_bank_bench;
  localparam logic [23:0] PHY_T = 24'h000040;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  evt_pulse = '0;
  logic        phy_err_valid = 1'b0;
  logic [4:0]  phy_err_type = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  mib_stat_bank #(.PHY_THR(PHY_T)) u_mib_stat_bank (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .phy_err_valid(phy_err_valid), .phy_err_type(phy_err_type),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: one pop per accepted response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: unexpected response 0x%0h expected none", rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_req(bit we, logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_wr(logic [3:0] a, logic [31:0] d);
    do_req(1'b1, a, d);
  endtask

  task automatic do_rd(logic [3:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    do_req(1'b0, a, '0);
  endtask

  task automatic pulse(logic [3:0] m, int n);
    @(posedge clk); #1; evt_pulse = m;
    repeat (n) @(posedge clk);
    #1; evt_pulse = '0;
  endtask

  task automatic phy(logic [4:0] t, int n);
    @(posedge clk); #1; phy_err_valid = 1; phy_err_type = t;
    repeat (n) @(posedge clk);
    #1; phy_err_valid = 0;
  endtask

  task automatic chk_irq(logic e, string tag);
    @(negedge clk);
    chk(tag, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state and address map
    chk_irq(1'b0, "R1 irq after reset");
    do_rd(4'd0, 32'h0, "R1 ctrl reset");
    for (int a = 1; a <= 8; a++) do_rd(a[3:0], 32'h0, "R1 reg reset");
    do_rd(4'd12, 32'h0, "R1 unmapped");
    // R2/R4: counting and clear-on-read
    pulse(4'b0001, 3);
    pulse(4'b1000, 5);
    do_wr(4'd1, 32'h55);
    do_rd(4'd1, 32'd3, "R2 rts_ok count");
    do_rd(4'd4, 32'd5, "R2 fcs count");
    do_rd(4'd1, 32'd0, "R4 cleared by read");
    pulse(4'b1111, 2);
    for (int a = 1; a <= 4; a++) do_rd(a[3:0], 32'd2, "R2 all four");
    // R5: mask selection
    do_wr(4'd6, 32'h0000_0088);
    do_wr(4'd8, 32'h0000_0080);
    phy(5'd3, 1); phy(5'd7, 2); phy(5'd9, 1);
    do_rd(4'd5, 32'd3, "R5 phy0 masked count");
    do_rd(4'd7, 32'd2, "R5 phy1 masked count");
    do_rd(4'd6, 32'h88, "R5 mask0 readback");
    // R8: strobe
    do_wr(4'd0, 32'h8);
    for (int i = 0; i < 6; i++) do_rd((i < 4) ? 4'(i + 1) : 4'(5 + 2 * (i - 4)), 32'd1, "R8 strobe");
    do_rd(4'd0, 32'h0, "R8 strobe bit reads 0");
    // R6: freeze
    pulse(4'b0010, 2);
    do_wr(4'd0, 32'h2);
    pulse(4'b0010, 4);
    do_wr(4'd0, 32'hA);
    phy(5'd7, 1);
    do_rd(4'd2, 32'd2, "R6 frozen value");
    do_rd(4'd2, 32'd2, "R6 frozen read no clear");
    do_rd(4'd7, 32'd0, "R6 frozen phy");
    do_rd(4'd0, 32'h2, "R6 ctrl freeze bit");
    do_wr(4'd0, 32'h0);
    do_rd(4'd2, 32'd2, "R6 after unfreeze");
    do_rd(4'd2, 32'd0, "R6 read clears again");
    // R7: clear and its priority
    pulse(4'b1111, 3);
    do_wr(4'd0, 32'h4);
    for (int a = 1; a <= 4; a++) do_rd(a[3:0], 32'd0, "R7 clear all");
    pulse(4'b1111, 1);
    phy(5'd7, 1);
    do_wr(4'd0, 32'hC);
    do_rd(4'd7, 32'd0, "R7 clear over strobe");
    do_rd(4'd1, 32'd0, "R7 clear over strobe frame");
    do_rd(4'd0, 32'h0, "R7 clear bit reads 0");
    // R4: read-clear racing own event
    pulse(4'b0100, 4);
    @(posedge clk); #1;
    evt_pulse = 4'b0100; req_valid = 1; req_write = 0; req_addr = 4'd3;
    exp_q.push_back(32'd4); tag_q.push_back("R4 read with event");
    @(posedge clk); #1;
    evt_pulse = '0; req_valid = 0;
    do_rd(4'd3, 32'd1, "R4 event kept after clear");
    // R11: back-pressure
    pulse(4'b0001, 1);
    @(posedge clk); #1 rsp_ready = 0;
    do_rd(4'd1, 32'd1, "R11 stalled response");
    repeat (3) begin
      @(negedge clk);
      chk("R11 valid held", {31'b0, rsp_valid}, 32'd1);
      chk("R11 req_ready low", {31'b0, req_ready}, 32'd0);
      chk("R11 data stable", rsp_rdata, 32'd1);
    end
    @(posedge clk); #1 rsp_ready = 1;
    // R3/R9/R10: frame saturation
    pulse(4'b0100, 32'hC000 + 10);
    chk_irq(1'b1, "R10 irq at threshold");
    do_rd(4'd0, 32'h1, "R9 warn set");
    do_rd(4'd3, 32'hC000, "R3 frame saturates");
    chk_irq(1'b1, "R10 irq held by warn");
    do_wr(4'd0, 32'h1);
    chk_irq(1'b1, "R9 writing 1 keeps warn");
    do_wr(4'd0, 32'h0);
    chk_irq(1'b0, "R10 irq released");
    do_rd(4'd0, 32'h0, "R9 warn cleared");
    // R3: PHY saturation
    phy(5'd3, 70);
    chk_irq(1'b1, "R10 phy irq");
    do_rd(4'd5, 32'(PHY_T), "R3 phy saturates");
    do_wr(4'd0, 32'h0);
    chk_irq(1'b0, "R10 phy irq released");
    repeat (5) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: actual %0d responses missing expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule